// File: doc/BRIEF.md
# CRC-4 Multiframe Loss Alarm Controller

This block follows the receive-side CRC-4 multiframe alignment state of a 2.048 Mbit/s framer. It does not search for alignment itself. It takes two inputs: a level that reports loss of basic frame alignment, and a strobe that reports that the external multiframe search has finished. When basic alignment is lost, the block enters the loss-of-multiframe state. When basic alignment returns, it issues a one-cycle search request. When the search-complete strobe arrives, it returns to the aligned state.

While the loss state holds, the block gates its neighbours. The two internal error counters stop and keep their values. The errored-second, continuous E-bit, Sa6 and Sa-stack monitor enables drop, and the Sa-stack interrupt is masked. Two configuration inputs can force the transmitted A bit to 1 and the transmitted E bits to 0. A set of duration counters, each with its own enable, advances on each one-second tick for as long as the loss lasts.

Top module: `mfa_loss_ctrl`

## Requirements
- R1: After reset, `mf_loss_o` is 1, `mf_srch_req_o` is 0, both error counters and all duration counters are 0, and `mon_en_o` is all zeros.
- R2: A clock edge that samples `bfa_lost_i` at 1 puts the block in the loss state (`mf_loss_o` = 1) from the following cycle. This holds in every state, and `bfa_lost_i` wins over a search-complete strobe sampled at the same edge.
- R3: When the block is waiting for basic alignment and samples `bfa_lost_i` at 0, `mf_srch_req_o` is 1 for exactly the next cycle and `mf_loss_o` stays 1.
- R4: A strobe on `mf_srch_done_i` during the search phase clears `mf_loss_o` in the next cycle. The same strobe while basic alignment is still lost has no effect.
- R5: `crc_err_cnt_o` counts one per cycle with `crc_err_i` high while aligned. It holds its value while `mf_loss_o` is 1.
- R6: `ebit_err_cnt_o` counts one per cycle with `ebit_err_i` high while aligned. It holds its value while `mf_loss_o` is 1.
- R7: `mon_en_o` is all ones while aligned and all zeros in the loss state. The bit meanings are: bit0 CRC-4 errored/severely errored seconds, bit1 E-bit errored/severely errored seconds, bit2 continuous E-bit monitor, bit3 Sa6 code monitor, bit4 Sa-stack update.
- R8: `sa_irq_o` follows `sa_irq_i` while aligned and is 0 in the loss state.
- R9: `tx_a_o` is 1 while `mf_loss_o` and `cfg_force_a_i` are both 1. Otherwise it equals `tx_a_i`.
- R10: `tx_e_o` is all zeros while `mf_loss_o` and `cfg_force_e_i` are both 1. Otherwise it equals `tx_e_i`.
- R11: Duration counter k occupies bits [k*PERF_W +: PERF_W] of `perf_cnt_o`. It counts `sec_tick_i` pulses while in the loss state with `cfg_perf_en_i[k]` = 1, and holds its value otherwise.
- R12: With SATURATE = 1, every counter stops at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bfa_lost_i | input | 1 | Basic frame alignment lost (level) |
| mf_srch_done_i | input | 1 | Multiframe search complete (strobe) |
| sec_tick_i | input | 1 | One-second tick |
| crc_err_i | input | 1 | CRC-4 block error event |
| ebit_err_i | input | 1 | Received E-bit error event |
| sa_irq_i | input | 1 | Sa-stack interrupt request |
| tx_a_i | input | 1 | A bit to transmit |
| tx_e_i | input | E_W | E bits to transmit |
| cfg_force_a_i | input | 1 | Enable forcing A = 1 during loss |
| cfg_force_e_i | input | 1 | Enable forcing E = 0 during loss |
| cfg_perf_en_i | input | NUM_PERF | Per-counter duration count enable |
| mf_loss_o | output | 1 | Loss-of-multiframe-alignment status |
| mf_srch_req_o | output | 1 | New multiframe search request pulse |
| crc_err_cnt_o | output | CNT_W | CRC-4 error count |
| ebit_err_cnt_o | output | CNT_W | E-bit error count |
| mon_en_o | output | 5 | Monitor enables |
| sa_irq_o | output | 1 | Gated Sa-stack interrupt |
| tx_a_o | output | 1 | A bit after override |
| tx_e_o | output | E_W | E bits after override |
| perf_cnt_o | output | NUM_PERF*PERF_W | Loss-duration counters |

## Verification
The state, the search request and every counter are registered, so they change one clock edge after the input that causes them. The bench drives each stimulus after a falling edge, lets one rising edge pass, and samples at the next falling edge. The monitor enables, the interrupt mask and the transmit overrides decode the state register without any further register, so the bench checks them in the same half-cycle as the state they depend on. For the counters, each event pulse lasts one cycle, and the expected totals come from event counts that the bench keeps itself. An event sampled in the cycle before the state changes is counted according to the old state.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
   typedef enum logic [1:0] {
      MFA_WAIT_BFA = 2'd0,
      MFA_SEARCH   = 2'd1,
      MFA_ALIGNED  = 2'd2
   } mfa_state_e;

   localparam int MON_N         = 5;
   localparam int MON_CRC_ES    = 0;
   localparam int MON_EBIT_ES   = 1;
   localparam int MON_EBIT_CONT = 2;
   localparam int MON_SA6       = 3;
   localparam int MON_SA_STACK  = 4;
endpackage

// File: rtl/mfa_state_fsm.sv
module mfa_state_fsm
   import mfa_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bfa_lost_i,
   input  logic       srch_done_i,
   output mfa_state_e state_o,
   output logic       srch_req_o
);
   mfa_state_e state_q;
   logic       req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MFA_WAIT_BFA;
         req_q   <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (bfa_lost_i) begin
            state_q <= MFA_WAIT_BFA;
         end else begin
            unique case (state_q)
               MFA_WAIT_BFA: begin
                  state_q <= MFA_SEARCH;
                  req_q   <= 1'b1;
               end
               MFA_SEARCH: begin
                  if (srch_done_i) state_q <= MFA_ALIGNED;
               end
               MFA_ALIGNED: state_q <= MFA_ALIGNED;
               default:     state_q <= MFA_WAIT_BFA;
            endcase
         end
      end
   end

   assign state_o    = state_q;
   assign srch_req_o = req_q;
endmodule

// File: rtl/mfa_sat_counter.sv
module mfa_sat_counter #(
   parameter int W        = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   logic [W-1:0] cnt_q;
   logic         step;

   generate
      if (SATURATE) begin : g_sat
         assign step = inc_i && (cnt_q != CNT_MAX);
      end else begin : g_wrap
         assign step = inc_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/mfa_tx_override.sv
module mfa_tx_override #(
   parameter int E_W = 2
) (
   input  logic           loss_i,
   input  logic           force_a_en_i,
   input  logic           force_e_en_i,
   input  logic           a_i,
   input  logic [E_W-1:0] e_i,
   output logic           a_o,
   output logic [E_W-1:0] e_o
);
   logic a_force;
   logic e_force;

   assign a_force = loss_i & force_a_en_i;
   assign e_force = loss_i & force_e_en_i;
   assign a_o     = a_i | a_force;

   generate
      for (genvar i = 0; i < E_W; i++) begin : g_ebit
         assign e_o[i] = e_i[i] & ~e_force;
      end
   endgenerate
endmodule

// File: rtl/mfa_loss_ctrl.sv
module mfa_loss_ctrl
   import mfa_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int PERF_W   = 16,
   parameter int NUM_PERF = 2,
   parameter int E_W      = 2,
   parameter bit SATURATE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bfa_lost_i,
   input  logic                       mf_srch_done_i,
   input  logic                       sec_tick_i,
   input  logic                       crc_err_i,
   input  logic                       ebit_err_i,
   input  logic                       sa_irq_i,
   input  logic                       tx_a_i,
   input  logic [E_W-1:0]             tx_e_i,
   input  logic                       cfg_force_a_i,
   input  logic                       cfg_force_e_i,
   input  logic [NUM_PERF-1:0]        cfg_perf_en_i,
   output logic                       mf_loss_o,
   output logic                       mf_srch_req_o,
   output logic [CNT_W-1:0]           crc_err_cnt_o,
   output logic [CNT_W-1:0]           ebit_err_cnt_o,
   output logic [MON_N-1:0]           mon_en_o,
   output logic                       sa_irq_o,
   output logic                       tx_a_o,
   output logic [E_W-1:0]             tx_e_o,
   output logic [NUM_PERF*PERF_W-1:0] perf_cnt_o
);
   localparam int PERF_BITS = NUM_PERF * PERF_W;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("mfa_loss_ctrl: CNT_W must lie in 2..32");
      end
      if (PERF_W < 2 || PERF_W > 32) begin : g_bad_perf_w
         $error("mfa_loss_ctrl: PERF_W must lie in 2..32");
      end
      if (NUM_PERF < 1 || NUM_PERF > 8) begin : g_bad_num_perf
         $error("mfa_loss_ctrl: NUM_PERF must lie in 1..8");
      end
      if (E_W < 1 || E_W > 2) begin : g_bad_e_w
         $error("mfa_loss_ctrl: E_W must be 1 or 2");
      end
   endgenerate

   mfa_state_e state;
   logic       aligned;
   logic       loss;

   mfa_state_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .bfa_lost_i  (bfa_lost_i),
      .srch_done_i (mf_srch_done_i),
      .state_o     (state),
      .srch_req_o  (mf_srch_req_o)
   );

   assign aligned = (state == MFA_ALIGNED);
   assign loss    = ~aligned;

   mfa_sat_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_crc_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (crc_err_i & aligned),
      .cnt_o (crc_err_cnt_o)
   );

   mfa_sat_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_ebit_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (ebit_err_i & aligned),
      .cnt_o (ebit_err_cnt_o)
   );

   logic [PERF_BITS-1:0] perf_flat;

   generate
      for (genvar k = 0; k < NUM_PERF; k++) begin : g_perf
         mfa_sat_counter #(.W(PERF_W), .SATURATE(SATURATE)) u_perf (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (sec_tick_i & loss & cfg_perf_en_i[k]),
            .cnt_o (perf_flat[k*PERF_W +: PERF_W])
         );
      end
      for (genvar m = 0; m < MON_N; m++) begin : g_mon
         assign mon_en_o[m] = aligned;
      end
   endgenerate

   assign perf_cnt_o = perf_flat;
   assign sa_irq_o   = sa_irq_i & aligned;
   assign mf_loss_o  = loss;

   mfa_tx_override #(.E_W(E_W)) u_tx (
      .loss_i       (loss),
      .force_a_en_i (cfg_force_a_i),
      .force_e_en_i (cfg_force_e_i),
      .a_i          (tx_a_i),
      .e_i          (tx_e_i),
      .a_o          (tx_a_o),
      .e_o          (tx_e_o)
   );
endmodule

// File: rtl/mfa_loss_chk.sv
module mfa_loss_chk #(
   parameter int CNT_W    = 16,
   parameter int PERF_W   = 16,
   parameter int NUM_PERF = 2,
   parameter int E_W      = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bfa_lost_i,
   input logic                       mf_srch_done_i,
   input logic                       cfg_force_a_i,
   input logic                       cfg_force_e_i,
   input logic                       mf_loss_o,
   input logic                       mf_srch_req_o,
   input logic [CNT_W-1:0]           crc_err_cnt_o,
   input logic [CNT_W-1:0]           ebit_err_cnt_o,
   input logic                       sa_irq_o,
   input logic                       tx_a_o,
   input logic [E_W-1:0]             tx_e_o,
   input logic [NUM_PERF*PERF_W-1:0] perf_cnt_o
);
   p_loss_after_bfa_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bfa_lost_i |=> mf_loss_o);

   p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mf_srch_req_o |=> !mf_srch_req_o);

   p_req_after_regain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mf_srch_req_o |-> (!$past(bfa_lost_i) && mf_loss_o));

   p_clear_needs_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mf_loss_o) |-> $past(mf_srch_done_i));

   p_crc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mf_loss_o |=> $stable(crc_err_cnt_o));

   p_ebit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mf_loss_o |=> $stable(ebit_err_cnt_o));

   p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mf_loss_o |-> !sa_irq_o);

   p_a_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_loss_o && cfg_force_a_i) |-> tx_a_o);

   p_e_forced_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_loss_o && cfg_force_e_i) |-> (tx_e_o == '0));

   p_perf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !mf_loss_o |=> $stable(perf_cnt_o));
endmodule

bind mfa_loss_ctrl mfa_loss_chk #(
   .CNT_W(CNT_W), .PERF_W(PERF_W), .NUM_PERF(NUM_PERF), .E_W(E_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bfa_lost_i     (bfa_lost_i),
   .mf_srch_done_i (mf_srch_done_i),
   .cfg_force_a_i  (cfg_force_a_i),
   .cfg_force_e_i  (cfg_force_e_i),
   .mf_loss_o      (mf_loss_o),
   .mf_srch_req_o  (mf_srch_req_o),
   .crc_err_cnt_o  (crc_err_cnt_o),
   .ebit_err_cnt_o (ebit_err_cnt_o),
   .sa_irq_o       (sa_irq_o),
   .tx_a_o         (tx_a_o),
   .tx_e_o         (tx_e_o),
   .perf_cnt_o     (perf_cnt_o)
);

// File: tb/mfa_loss_ctrl_tb.sv
module mfa_loss_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 4;
   localparam int PERF_W     = 3;
   localparam int NUM_PERF   = 2;
   localparam int E_W        = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bfa_lost_i = 1'b1, mf_srch_done_i = 1'b0, sec_tick_i = 1'b0;
   logic crc_err_i = 1'b0, ebit_err_i = 1'b0, sa_irq_i = 1'b0, tx_a_i = 1'b0;
   logic [E_W-1:0] tx_e_i = '0;
   logic cfg_force_a_i = 1'b0, cfg_force_e_i = 1'b0;
   logic [NUM_PERF-1:0] cfg_perf_en_i = '0;
   logic mf_loss_o, mf_srch_req_o, sa_irq_o, tx_a_o;
   logic [CNT_W-1:0] crc_err_cnt_o, ebit_err_cnt_o;
   logic [4:0] mon_en_o;
   logic [E_W-1:0] tx_e_o;
   logic [NUM_PERF*PERF_W-1:0] perf_cnt_o;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;
   int exp_crc = 0, exp_ebit = 0, exp_p0 = 0, exp_p1 = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mfa_loss_ctrl #(.CNT_W(CNT_W), .PERF_W(PERF_W), .NUM_PERF(NUM_PERF),
                   .E_W(E_W), .SATURATE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .bfa_lost_i(bfa_lost_i),
      .mf_srch_done_i(mf_srch_done_i), .sec_tick_i(sec_tick_i),
      .crc_err_i(crc_err_i), .ebit_err_i(ebit_err_i), .sa_irq_i(sa_irq_i),
      .tx_a_i(tx_a_i), .tx_e_i(tx_e_i), .cfg_force_a_i(cfg_force_a_i),
      .cfg_force_e_i(cfg_force_e_i), .cfg_perf_en_i(cfg_perf_en_i),
      .mf_loss_o(mf_loss_o), .mf_srch_req_o(mf_srch_req_o),
      .crc_err_cnt_o(crc_err_cnt_o), .ebit_err_cnt_o(ebit_err_cnt_o),
      .mon_en_o(mon_en_o), .sa_irq_o(sa_irq_o), .tx_a_o(tx_a_o),
      .tx_e_o(tx_e_o), .perf_cnt_o(perf_cnt_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int sat(input int v, input int w);
      return (v > (1 << w) - 1) ? (1 << w) - 1 : v;
   endfunction

   task automatic check_counts(input string req);
      check({req, " crc count"},  int'(crc_err_cnt_o),  sat(exp_crc, CNT_W));
      check({req, " ebit count"}, int'(ebit_err_cnt_o), sat(exp_ebit, CNT_W));
      check({req, " perf0"}, int'(perf_cnt_o[0 +: PERF_W]), sat(exp_p0, PERF_W));
      check({req, " perf1"}, int'(perf_cnt_o[PERF_W +: PERF_W]), sat(exp_p1, PERF_W));
   endtask

   task automatic pulse_events(input int n_crc, input int n_ebit, input bit counted);
      for (int i = 0; i < n_crc || i < n_ebit; i++) begin
         crc_err_i  = (i < n_crc);
         ebit_err_i = (i < n_ebit);
         step();
      end
      crc_err_i = 1'b0; ebit_err_i = 1'b0;
      if (counted) begin exp_crc += n_crc; exp_ebit += n_ebit; end
   endtask

   task automatic realign();
      bfa_lost_i = 1'b0;
      step();
      check("R3 request pulse", mf_srch_req_o, 1);
      check("R3 loss kept during search", mf_loss_o, 1);
      step();
      check("R3 request one cycle", mf_srch_req_o, 0);
      mf_srch_done_i = 1'b1;
      step();
      mf_srch_done_i = 1'b0;
      check("R4 aligned after done", mf_loss_o, 0);
   endtask

   task automatic t_reset_r1();
      check("R1 loss at reset", mf_loss_o, 1);
      check("R1 request idle", mf_srch_req_o, 0);
      check("R1 monitors off", int'(mon_en_o), 0);
      check_counts("R1");
   endtask

   task automatic t_done_ignored_r4();
      mf_srch_done_i = 1'b1;
      step();
      mf_srch_done_i = 1'b0;
      check("R4 done ignored while bfa lost", mf_loss_o, 1);
      check("R4 no request while bfa lost", mf_srch_req_o, 0);
   endtask

   task automatic t_aligned_counting_r5_r6();
      realign();
      check("R7 monitors on", int'(mon_en_o), 31);
      pulse_events(3, 2, 1'b1);
      check_counts("R5 R6 aligned");
      sa_irq_i = 1'b1;
      #1 check("R8 irq passes", sa_irq_o, 1);
      sa_irq_i = 1'b0;
   endtask

   task automatic t_tx_aligned_r9_r10();
      cfg_force_a_i = 1'b1; cfg_force_e_i = 1'b1;
      tx_a_i = 1'b0; tx_e_i = 2'b11;
      #1;
      check("R9 A passes aligned", tx_a_o, 0);
      check("R10 E passes aligned", int'(tx_e_o), 3);
   endtask

   task automatic t_bfa_priority_r2();
      bfa_lost_i = 1'b1; mf_srch_done_i = 1'b1;
      step();
      mf_srch_done_i = 1'b0;
      check("R2 loss wins over done", mf_loss_o, 1);
      check("R7 monitors off in loss", int'(mon_en_o), 0);
      sa_irq_i = 1'b1;
      #1 check("R8 irq masked", sa_irq_o, 0);
      sa_irq_i = 1'b0;
      check("R9 A forced", tx_a_o, 1);
      check("R10 E forced", int'(tx_e_o), 0);
      cfg_force_a_i = 1'b0; cfg_force_e_i = 1'b0; tx_e_i = 2'b10;
      #1;
      check("R9 A passes unforced", tx_a_o, 0);
      check("R10 E passes unforced", int'(tx_e_o), 2);
   endtask

   task automatic t_loss_hold_r11();
      pulse_events(4, 4, 1'b0);
      check_counts("R5 R6 hold in loss");
      cfg_perf_en_i = 2'b01;
      for (int i = 0; i < 3; i++) begin
         sec_tick_i = 1'b1; step(); sec_tick_i = 1'b0; step();
      end
      exp_p0 += 3;
      check_counts("R11 duration");
      realign();
      sec_tick_i = 1'b1; step(); sec_tick_i = 1'b0;
      check_counts("R11 held while aligned");
   endtask

   task automatic t_saturate_r12();
      pulse_events(20, 1, 1'b1);
      check_counts("R12 error saturate");
      bfa_lost_i = 1'b1;
      step();
      cfg_perf_en_i = 2'b11;
      for (int i = 0; i < 10; i++) begin
         sec_tick_i = 1'b1; step();
      end
      sec_tick_i = 1'b0;
      exp_p0 += 10; exp_p1 += 10;
      check_counts("R12 perf saturate");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset_r1();
      t_done_ignored_r4();
      t_aligned_counting_r5_r6();
      t_tx_aligned_r9_r10();
      t_bfa_priority_r2();
      t_loss_hold_r11();
      t_saturate_r12();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule